// File: doc/BRIEF.md
# MII nibble MAC front-end

This block sits between a 4-bit media-independent interface and the byte-wide frame path of one switch port. Its receive side watches the line's nibble stream. When data-valid is raised it hunts for the start-of-frame delimiter. It then packs the nibbles that follow into bytes, low nibble first, and delivers them as one-cycle beats. The first beat of a frame carries a start marker and the last beat carries an end marker plus error and dribble status. Its transmit side takes bytes from a frame source and sends them on the line as nibbles. Each frame starts with a preamble and the delimiter, and the transmit enable rises with the very first preamble nibble.

All logic runs on one system clock. In normal mode the two line clocks come from the physical-layer device; the block oversamples them and acts on their edges. Receive data is taken on the rising edge by default, or on the falling edge when a select input asks for it. Transmit nibbles are launched on the falling edge of the transmit clock. A reversed-mode input makes the port play the PHY's role towards an external MAC. The block then generates the line clock itself by dividing the system clock, drives it on both clock outputs, samples the peer's transmit nibbles on its rising edge, launches its own nibbles on its falling edge, and drives carrier sense.

Top module: `mii_nibble_mac`

## Requirements
- R1: After reset, the line enable, line data, all clock outputs, carrier sense, collision and every receive beat output are low.
- R2: In normal mode, receive nibbles are taken at the rising edge of `ln_rxclk_i` when `rx_fall_sel` is 0, and at its falling edge when it is 1. A byte beat appears in the system cycle right after the sample that completes it.
- R3: While data-valid is high, every nibble up to and including the first one equal to 0xD is discarded. The nibbles after that 0xD are frame data, even if they equal 0xD.
- R4: Data nibbles are paired low nibble first into `rx_data`, each byte on a one-cycle `rx_valid` beat. `rx_sof` marks the first byte of a frame. `rx_eof` marks the last byte, which is delivered once data-valid is sampled low.
- R5: If data-valid falls after an odd number of data nibbles, the unpaired nibble is dropped and `rx_dribble` is set on the end beat. `rx_err` and `rx_dribble` are never high on a beat without `rx_eof`.
- R6: If the error input is high at any sample taken with data-valid high during a frame, `rx_err` is set on that frame's end beat.
- R7: A transmitted frame is sixteen 0x5 nibbles, then 0xD, then each byte low nibble first. `ln_txen_o` rises in the same cycle that the first 0x5 appears. `tx_ready` pulses once per byte, in the cycle where that byte's high nibble is launched.
- R8: The line data and enable change only on a transmit-clock falling edge. When `tx_last` was set on the byte just sent, the enable drops at the next falling edge.
- R9: If `tx_valid` is low when a low nibble is due, the enable drops at that edge and the frame ends.
- R10: In reversed mode, `ln_rclk_o` and `ln_tclk_o` carry the same divided clock: period `CLK_DIV` system cycles, high for the first half. `ln_crs_o` equals enable-out OR data-valid-in. In normal mode the clock outputs and `ln_crs_o` stay low. `ln_col_o` is always low.
- R11: In reversed mode, receive samples are taken at the rising edge of the generated clock and transmit nibbles are launched at its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rev_mode | input | 1 | 1: act as the PHY side of the link |
| rx_fall_sel | input | 1 | 1: sample receive data on the falling edge of the line receive clock (normal mode) |
| ln_rxclk_i | input | 1 | Line receive clock from the PHY (normal mode) |
| ln_txclk_i | input | 1 | Line transmit clock from the PHY (normal mode) |
| ln_rxd_i | input | 4 | Incoming nibble (PHY receive data, or the peer MAC's transmit data in reversed mode) |
| ln_rxdv_i | input | 1 | Incoming data valid (peer's transmit enable in reversed mode) |
| ln_rxer_i | input | 1 | Incoming error (peer's transmit error in reversed mode) |
| ln_txd_o | output | 4 | Outgoing nibble |
| ln_txen_o | output | 1 | Outgoing enable (acts as data valid to the peer in reversed mode) |
| ln_rclk_o | output | 1 | Generated receive clock in reversed mode, else 0 |
| ln_tclk_o | output | 1 | Generated transmit clock in reversed mode, else 0 |
| ln_crs_o | output | 1 | Carrier sense in reversed mode, else 0 |
| ln_col_o | output | 1 | Collision, held low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_last | input | 1 | `tx_data` is the last byte of the frame |
| tx_ready | output | 1 | Byte consumed in this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Beat strobe for `rx_data` |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last byte of a frame |
| rx_err | output | 1 | Frame saw a receive error (end beat only) |
| rx_dribble | output | 1 | Frame ended on an odd nibble (end beat only) |

## Verification
The receive end-of-frame beat, the error flag and the dribble flag are all decided by one sampling edge: the one that finds data-valid low. In that same cycle the held-back last byte must be released. The bench provokes this by ending one frame on an odd nibble and by raising the error input on a data nibble of another frame. It checks that the flags appear only on the beat that carries `rx_eof`, that the held byte is intact, and that no extra beat is produced by the dropped nibble. The phase of the line clock at each delivered beat is also recorded, which tells rising-edge sampling apart from falling-edge sampling.

// File: rtl/mii_mac_pkg.sv
package mii_mac_pkg;
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 8;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;
  // number of 0x5 nibbles sent before the 0xD that closes the delimiter
  localparam int PRE_FIVES = 16;

  typedef enum logic {RX_HUNT, RX_DATA} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_DATA, TX_END} tx_state_e;

  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] lo,
                                                     input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [NIB_W-1:0] pick_nibble(input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    return hi ? b[BYTE_W-1 -: NIB_W] : b[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/mii_clk_events.sv
module mii_clk_events #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rev_mode,
  input  logic rx_fall_sel,
  input  logic rxclk_i,
  input  logic txclk_i,
  output logic rx_tick,
  output logic tx_tick,
  output logic gclk
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt;
  logic rx_q, tx_q;
  logic ext_rx_edge, ext_tx_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CW'(CLK_DIV - 1);
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      cnt  <= (cnt == CW'(CLK_DIV - 1)) ? '0 : cnt + 1'b1;
      rx_q <= rxclk_i;
      tx_q <= txclk_i;
    end
  end

  // edges of the PHY-driven clocks, seen in the first cycle at the new level
  assign ext_rx_edge = rx_fall_sel ? (rx_q & ~rxclk_i) : (~rx_q & rxclk_i);
  assign ext_tx_edge = tx_q & ~txclk_i;

  assign gclk    = cnt < CW'(HALF);
  assign rx_tick = rev_mode ? (cnt == '0) : ext_rx_edge;
  assign tx_tick = rev_mode ? (cnt == CW'(HALF)) : ext_tx_edge;
endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
  import mii_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NIB_W-1:0]  nib,
  input  logic              dv,
  input  logic              er,
  output logic [BYTE_W-1:0] data,
  output logic              valid,
  output logic              sof,
  output logic              eof,
  output logic              err,
  output logic              dribble
);
  rx_state_e         st;
  logic              half;
  logic [NIB_W-1:0]  lo;
  logic [BYTE_W-1:0] held;
  logic              held_v, held_first, first, er_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_HUNT;  half <= 1'b0;  lo <= '0;  held <= '0;
      held_v <= 1'b0; held_first <= 1'b0; first <= 1'b0; er_seen <= 1'b0;
      data <= '0; valid <= 1'b0; sof <= 1'b0; eof <= 1'b0;
      err <= 1'b0; dribble <= 1'b0;
    end else begin
      valid <= 1'b0; sof <= 1'b0; eof <= 1'b0; err <= 1'b0; dribble <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_HUNT: begin
            if (!dv) er_seen <= 1'b0;
            else begin
              if (er) er_seen <= 1'b1;
              if (nib == SFD_NIB) begin
                st <= RX_DATA; half <= 1'b0; held_v <= 1'b0; first <= 1'b1;
              end
            end
          end
          RX_DATA: begin
            if (!dv) begin
              // release the held byte as the frame's last one
              if (held_v) begin
                valid <= 1'b1; data <= held; sof <= held_first; eof <= 1'b1;
                err <= er_seen; dribble <= half;
              end
              st <= RX_HUNT; er_seen <= 1'b0; held_v <= 1'b0; half <= 1'b0;
            end else begin
              if (er) er_seen <= 1'b1;
              if (!half) begin
                lo <= nib; half <= 1'b1;
              end else begin
                half <= 1'b0;
                if (held_v) begin
                  valid <= 1'b1; data <= held; sof <= held_first;
                end
                held <= join_nibbles(lo, nib);
                held_v <= 1'b1; held_first <= first; first <= 1'b0;
              end
            end
          end
          default: st <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_valid,
  input  logic              src_last,
  output logic              src_ready,
  output logic [NIB_W-1:0]  txd,
  output logic              txen
);
  localparam int PCW = $clog2(PRE_FIVES + 1);

  tx_state_e      st;
  logic [PCW-1:0] pcnt;
  logic           half;

  assign src_ready = tick && (st == TX_DATA) && half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; pcnt <= '0; half <= 1'b0; txd <= '0; txen <= 1'b0;
    end else if (tick) begin
      unique case (st)
        TX_IDLE: if (src_valid) begin
          txen <= 1'b1; txd <= PRE_NIB; pcnt <= PCW'(1); st <= TX_PRE;
        end
        TX_PRE: if (pcnt == PCW'(PRE_FIVES)) begin
          txd <= SFD_NIB; st <= TX_DATA; half <= 1'b0;
        end else begin
          txd <= PRE_NIB; pcnt <= pcnt + 1'b1;
        end
        TX_DATA: if (!half) begin
          if (!src_valid) begin
            txen <= 1'b0; txd <= '0; st <= TX_IDLE;
          end else begin
            txd <= pick_nibble(src_data, 1'b0); half <= 1'b1;
          end
        end else begin
          txd <= pick_nibble(src_data, 1'b1); half <= 1'b0;
          if (src_last) st <= TX_END;
        end
        TX_END: begin
          txen <= 1'b0; txd <= '0; st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_nibble_mac.sv
module mii_nibble_mac
  import mii_mac_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_mode,
  input  logic              rx_fall_sel,
  input  logic              ln_rxclk_i,
  input  logic              ln_txclk_i,
  input  logic [NIB_W-1:0]  ln_rxd_i,
  input  logic              ln_rxdv_i,
  input  logic              ln_rxer_i,
  output logic [NIB_W-1:0]  ln_txd_o,
  output logic              ln_txen_o,
  output logic              ln_rclk_o,
  output logic              ln_tclk_o,
  output logic              ln_crs_o,
  output logic              ln_col_o,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_sof,
  output logic              rx_eof,
  output logic              rx_err,
  output logic              rx_dribble
);
  logic rx_tick, tx_tick, gclk;

  mii_clk_events #(.CLK_DIV(CLK_DIV)) u_events (
    .clk(clk), .rst_n(rst_n), .rev_mode(rev_mode), .rx_fall_sel(rx_fall_sel),
    .rxclk_i(ln_rxclk_i), .txclk_i(ln_txclk_i),
    .rx_tick(rx_tick), .tx_tick(tx_tick), .gclk(gclk)
  );

  mii_rx_deframer u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick),
    .nib(ln_rxd_i), .dv(ln_rxdv_i), .er(ln_rxer_i),
    .data(rx_data), .valid(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .err(rx_err), .dribble(rx_dribble)
  );

  mii_tx_framer u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick),
    .src_data(tx_data), .src_valid(tx_valid), .src_last(tx_last),
    .src_ready(tx_ready), .txd(ln_txd_o), .txen(ln_txen_o)
  );

  assign ln_rclk_o = rev_mode & gclk;
  assign ln_tclk_o = rev_mode & gclk;
  assign ln_crs_o  = rev_mode & (ln_txen_o | ln_rxdv_i);
  assign ln_col_o  = 1'b0;
endmodule

// File: rtl/mii_nibble_mac_chk.sv
module mii_nibble_mac_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rev_mode,
  input logic       rx_tick,
  input logic       tx_tick,
  input logic       tx_ready,
  input logic [3:0] ln_txd_o,
  input logic       ln_txen_o,
  input logic       ln_rclk_o,
  input logic       ln_tclk_o,
  input logic       ln_crs_o,
  input logic       ln_col_o,
  input logic       rx_valid,
  input logic       rx_eof,
  input logic       rx_err,
  input logic       rx_dribble
);
  AST_RX_BEAT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_tick)); // R2
  AST_DRIBBLE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dribble |-> (rx_valid && rx_eof)); // R5
  AST_ERR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_valid && rx_eof)); // R6
  AST_TXEN_WITH_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ln_txen_o) |-> (ln_txd_o == 4'h5)); // R7
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ln_txen_o); // R7
  AST_TX_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ln_txd_o) || !$stable(ln_txen_o)) |-> $past(tx_tick)); // R8
  AST_CLK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ln_rclk_o == ln_tclk_o); // R10
  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_mode |-> (!ln_rclk_o && !ln_crs_o)); // R10
  AST_COL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ln_col_o); // R10
  AST_REV_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_mode && $past(rev_mode) && rx_tick) |-> (ln_rclk_o && !$past(ln_rclk_o))); // R11
  AST_REV_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_mode && $past(rev_mode) && tx_tick) |-> (!ln_tclk_o && $past(ln_tclk_o))); // R11
endmodule

bind mii_nibble_mac mii_nibble_mac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rev_mode(rev_mode), .rx_tick(rx_tick),
  .tx_tick(tx_tick), .tx_ready(tx_ready), .ln_txd_o(ln_txd_o),
  .ln_txen_o(ln_txen_o), .ln_rclk_o(ln_rclk_o), .ln_tclk_o(ln_tclk_o),
  .ln_crs_o(ln_crs_o), .ln_col_o(ln_col_o), .rx_valid(rx_valid),
  .rx_eof(rx_eof), .rx_err(rx_err), .rx_dribble(rx_dribble)
);

// File: tb/mii_nibble_mac_tb.sv
module mii_nibble_mac_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       rev_mode = 0, rx_fall_sel = 0, mclk = 0, mclk_run = 0;
  logic [3:0] ln_rxd_i = 0;
  logic       ln_rxdv_i = 0, ln_rxer_i = 0;
  logic [7:0] tx_data = 0;
  logic       tx_valid = 0, tx_last = 0;
  logic [3:0] ln_txd_o;
  logic       ln_txen_o, ln_rclk_o, ln_tclk_o, ln_crs_o, ln_col_o, tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, rx_sof, rx_eof, rx_err, rx_dribble;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pl [4];
  logic [7:0] rb_data [16];
  logic [4:0] rb_flag [16];   // {phase, dribble, err, eof, sof}
  int rb_n = 0;
  logic [3:0] cap [64];
  int cap_n = 0;

  mii_nibble_mac u_dut (
    .clk(clk), .rst_n(rst_n), .rev_mode(rev_mode), .rx_fall_sel(rx_fall_sel),
    .ln_rxclk_i(mclk), .ln_txclk_i(mclk), .ln_rxd_i(ln_rxd_i),
    .ln_rxdv_i(ln_rxdv_i), .ln_rxer_i(ln_rxer_i), .ln_txd_o(ln_txd_o),
    .ln_txen_o(ln_txen_o), .ln_rclk_o(ln_rclk_o), .ln_tclk_o(ln_tclk_o),
    .ln_crs_o(ln_crs_o), .ln_col_o(ln_col_o), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_err(rx_err), .rx_dribble(rx_dribble)
  );

  // PHY-side line clock: period of four system cycles
  initial forever begin
    @(negedge clk); @(negedge clk);
    if (mclk_run) mclk = ~mclk;
  end

  // receive beat monitor, sampled away from the clock edge
  initial forever begin
    @(posedge clk); #2;
    if (rx_valid && rb_n < 16) begin
      rb_data[rb_n] = rx_data;
      rb_flag[rb_n] = {(rev_mode ? ln_rclk_o : mclk), rx_dribble, rx_err, rx_eof, rx_sof};
      rb_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  task automatic rx_nib(input logic [3:0] n, input logic dv, input logic er);
    if (rev_mode) @(negedge ln_rclk_o);
    else if (rx_fall_sel) @(posedge mclk);
    else @(negedge mclk);
    #1;
    ln_rxd_i = n; ln_rxdv_i = dv; ln_rxer_i = er;
  endtask

  // sends junk, delimiter, n bytes, optional odd nibble; er on data nibble er_at
  task automatic rx_frame(input int n, input bit odd, input int er_at);
    int k;
    bit lvl;
    rb_n = 0;
    rx_nib(4'h5, 1, 0); rx_nib(4'h3, 1, 0); rx_nib(4'h5, 1, 0); rx_nib(4'hD, 1, 0);
    k = 0;
    for (int i = 0; i < n; i++) begin
      rx_nib(pl[i][3:0], 1, k == er_at); k++;
      rx_nib(pl[i][7:4], 1, k == er_at); k++;
    end
    if (odd) rx_nib(4'h9, 1, 0);
    rx_nib(4'h0, 0, 0);
    repeat (12) @(posedge clk);
    #3;
    lvl = rev_mode ? 1'b1 : !rx_fall_sel;
    chk(rb_n == n, "R4 beat count", rb_n, n);
    for (int i = 0; i < n && i < rb_n; i++) begin
      chk(rb_data[i] == pl[i], "R3 R4 byte value", rb_data[i], pl[i]);
      chk(rb_flag[i][0] == (i == 0), "R4 sof", rb_flag[i][0], i == 0);
      chk(rb_flag[i][1] == (i == n - 1), "R4 eof", rb_flag[i][1], i == n - 1);
      chk(rb_flag[i][2] == ((er_at >= 0) && (i == n - 1)), "R6 err", rb_flag[i][2],
          (er_at >= 0) && (i == n - 1));
      chk(rb_flag[i][3] == (odd && (i == n - 1)), "R5 dribble", rb_flag[i][3],
          odd && (i == n - 1));
      chk(rb_flag[i][4] == lvl, rev_mode ? "R11 sample edge" : "R2 sample edge",
          rb_flag[i][4], lvl);
    end
  endtask

  function automatic logic [3:0] exp_nib(input int i);
    int j;
    if (i < 16) return 4'h5;
    if (i == 16) return 4'hD;
    j = i - 17;
    return (j % 2) ? pl[j/2][7:4] : pl[j/2][3:0];
  endfunction

  task automatic tx_frame(input int n, input bit use_last);
    cap_n = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          tx_data = pl[i]; tx_last = use_last && (i == n - 1); tx_valid = 1;
          do begin @(negedge clk); #1; end while (!tx_ready);
          @(posedge clk); #1;
        end
        tx_valid = 0; tx_last = 0;
      end
      begin
        logic [3:0] nb;
        wait (ln_txen_o === 1'b1);
        while (cap_n < 64) begin
          if (rev_mode) @(posedge ln_tclk_o); else @(posedge mclk);
          #1;
          if (!ln_txen_o) break;
          if (cap_n == 0 && rev_mode) chk(ln_crs_o == 1'b1, "R10 carrier", ln_crs_o, 1);
          nb = ln_txd_o;
          #18;
          chk(ln_txd_o == nb && ln_txen_o, rev_mode ? "R11 launch edge" : "R8 launch edge",
              ln_txd_o, nb);
          cap[cap_n] = nb;
          cap_n++;
        end
      end
    join
    chk(cap_n == 17 + 2 * n, use_last ? "R8 frame length" : "R9 frame length",
        cap_n, 17 + 2 * n);
    for (int i = 0; i < cap_n && i < 17 + 2 * n; i++)
      chk(cap[i] == exp_nib(i), "R7 nibble order", cap[i], exp_nib(i));
  endtask

  task automatic test_reset();
    chk(ln_txen_o == 0 && ln_txd_o == 0, "R1 line out", {ln_txen_o, ln_txd_o}, 0);
    chk(rx_valid == 0 && rx_sof == 0 && rx_eof == 0, "R1 rx beat", rx_valid, 0);
    chk(ln_rclk_o == 0 && ln_tclk_o == 0 && ln_crs_o == 0 && ln_col_o == 0,
        "R1 aux out", {ln_rclk_o, ln_tclk_o, ln_crs_o, ln_col_o}, 0);
  endtask

  task automatic test_normal_quiet();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ln_rclk_o == 0 && ln_tclk_o == 0 && ln_crs_o == 0, "R10 normal quiet",
          {ln_rclk_o, ln_tclk_o, ln_crs_o}, 0);
    end
  endtask

  task automatic test_rev_clocks();
    logic s [8];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s[i] = ln_rclk_o;
      chk(ln_rclk_o == ln_tclk_o, "R10 clock pair", ln_tclk_o, ln_rclk_o);
      chk(ln_col_o == 0, "R10 collision low", ln_col_o, 0);
    end
    for (int i = 0; i < 4; i++) begin
      chk(s[i] != s[i+2], "R10 half period", s[i+2], !s[i]);
      chk(s[i] == s[i+4], "R10 full period", s[i+4], s[i]);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    mclk_run = 1;
    test_normal_quiet();

    pl[0] = 8'hA7; pl[1] = 8'h3C; pl[2] = 8'h01;
    rx_frame(3, 0, -1);                       // R2 rising, R3 hunt, R4
    rx_fall_sel = 1;
    pl[0] = 8'h5A; pl[1] = 8'hD5;
    rx_frame(2, 0, -1);                       // R2 falling edge
    rx_fall_sel = 0;
    pl[0] = 8'h12;
    rx_frame(1, 1, -1);                       // R5 dribble
    pl[0] = 8'hFF; pl[1] = 8'h00;
    rx_frame(2, 0, 2);                        // R6 error on a data nibble

    pl[0] = 8'hA5; pl[1] = 8'h0F;
    tx_frame(2, 1);                           // R7 R8 with tx_last
    repeat (8) @(posedge clk);
    pl[0] = 8'hC3;
    tx_frame(1, 0);                           // R9 underrun end
    repeat (8) @(posedge clk);

    rev_mode = 1;
    test_rev_clocks();                        // R10
    pl[0] = 8'h96; pl[1] = 8'hE1;
    rx_frame(2, 0, -1);                       // R11 receive in reversed mode
    pl[0] = 8'h7E;
    tx_frame(1, 1);                           // R11 transmit in reversed mode
    repeat (8) @(posedge clk);
    summary();
  end
endmodule